// File: doc/BRIEF.md
# Split Integer/Float Register Rename Table

This block holds the speculative map from architectural to physical registers for an out-of-order core. The core has two physical pools, integer and floating point, and a range of control registers. One flat architectural index space covers all three classes: integer indices come first, then float indices, then control indices. Physical integer registers occupy `[0, PHYS_INT)`. Physical float registers occupy `[PHYS_INT, PHYS_INT+PHYS_FLT)`. Control registers are placed above every physical register by fixed offset arithmetic and never use the table.

The rename port handles one destination per cycle. It reports the mapping the destination had before the rename and the mapping it gets now. For a renamed destination it pops one register from the matching external free list; the popped register is presented on a show-ahead input. Several lookup ports answer source reads combinationally. A set-entry port rewrites integer or float entries during recovery. A free-count output gives the smaller of the two free-list counts, so the front end can limit how many renames it issues. The free lists, checkpoints and the reorder buffer are outside this block.

The zero registers, one integer and one float, keep their fixed mapping. The rename response and the lookup ports are combinational. Table writes take effect at the rising clock edge.

Top module: `rename_table`

## Requirements
- R1: After reset, integer index i (i < LOG_INT) maps to physical i, and float index LOG_INT+j maps to physical PHYS_INT+j.
- R2: Each lookup port is combinational. For an integer or float index it returns the current table entry. For a control index a (a >= LOG_INT+LOG_FLT) it returns a - (LOG_INT+LOG_FLT) + (PHYS_INT+PHYS_FLT).
- R3: A rename of a non-zero integer or float index does four things. It returns the current entry on `ren_prev_o`. It raises exactly one of `int_pop_o` or `flt_pop_o`, matching the class of the index. It returns the popped register on `ren_new_o`. It writes that register into the entry at the clock edge. A popped register must lie in its pool's physical range.
- R4: A rename of the integer zero index (INT_ZERO) or the float zero index (FLT_ZERO) pops nothing. It returns the current entry on both `ren_new_o` and `ren_prev_o` and leaves the entry unchanged.
- R5: A rename of a control index is never stalled and pops nothing. It returns the offset value of R2 on both `ren_new_o` and `ren_prev_o`.
- R6: A set-entry write replaces an integer or float entry at the clock edge. A set-entry write that targets a control index changes nothing.
- R7: `free_cnt_o` equals the minimum of `int_free_cnt_i` and `flt_free_cnt_i`.
- R8: When the free list the rename needs reports empty, `ren_ready_o` is low, nothing is popped and the table is not written. The other list being empty has no effect on the rename.
- R9: A lookup of the index being renamed in the same cycle returns the mapping from before the update.
- R10: When a set-entry write and a rename hit the same index in the same cycle, the set-entry value is stored. The rename still pops and reports its new and previous mappings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ren_valid_i | input | 1 | Rename request |
| ren_arch_i | input | AW | Destination architectural index |
| ren_ready_o | output | 1 | Rename can complete this cycle |
| ren_new_o | output | PW | New physical mapping |
| ren_prev_o | output | PW | Previous physical mapping |
| int_pop_o | output | 1 | Pop integer free list |
| int_pop_reg_i | input | PW | Integer free-list head |
| int_empty_i | input | 1 | Integer free list empty |
| flt_pop_o | output | 1 | Pop float free list |
| flt_pop_reg_i | input | PW | Float free-list head |
| flt_empty_i | input | 1 | Float free list empty |
| int_free_cnt_i | input | CW | Integer free count |
| flt_free_cnt_i | input | CW | Float free count |
| free_cnt_o | output | CW | Minimum of the two free counts |
| lk_arch_i | input | NUM_RD x AW | Lookup indices |
| lk_phys_o | output | NUM_RD x PW | Lookup results |
| set_valid_i | input | 1 | Set-entry write |
| set_arch_i | input | AW | Set-entry index |
| set_phys_i | input | PW | Set-entry value |

## Verification
Lookups sweep every architectural index after reset and again after each phase. The two lookup ports read mirrored indices, which shows whether the ports are independent and whether each class boundary sits at the right place. Every non-zero integer and float index is renamed with a distinct head value. That tells the previous mapping apart from the new one, and pops of the integer pool apart from pops of the float pool. Separate patterns cover the following:
- the zero and control indices;
- an empty list, alone and paired with the other class;
- a set-entry write to a control index, followed by a full sweep;
- a set-entry write and a rename on the same index;
- a grid of free-count pairs that shows which input is the minimum.

// File: rtl/rename_table_pkg.sv
package rename_table_pkg;
  typedef enum logic [1:0] {
    RC_INT  = 2'd0,
    RC_FLT  = 2'd1,
    RC_CTRL = 2'd2
  } reg_cls_e;
endpackage

// File: rtl/rename_table_decode.sv
module rename_table_decode
  import rename_table_pkg::*;
#(
  parameter int LOG_INT  = 8,
  parameter int LOG_FLT  = 8,
  parameter int PHYS_TOT = 32,
  parameter int AW       = 5,
  parameter int PW       = 6
) (
  input  logic [AW-1:0] arch_i,
  output reg_cls_e      cls_o,
  output logic [PW-1:0] ctrl_map_o
);
  localparam int LOG_TOT = LOG_INT + LOG_FLT;
  localparam logic [AW-1:0] INT_LIM = AW'(LOG_INT);
  localparam logic [AW-1:0] TOT_LIM = AW'(LOG_TOT);

  always_comb begin
    if (arch_i < INT_LIM)      cls_o = RC_INT;
    else if (arch_i < TOT_LIM) cls_o = RC_FLT;
    else                       cls_o = RC_CTRL;
  end

  // modular arithmetic in PW bits; result always fits below 2**PW
  assign ctrl_map_o = PW'(arch_i) - PW'(LOG_TOT) + PW'(PHYS_TOT);
endmodule

// File: rtl/rename_table_store.sv
module rename_table_store #(
  parameter int LOG_INT  = 8,
  parameter int ENTRIES  = 16,
  parameter int PHYS_INT = 16,
  parameter int PW       = 6,
  parameter int TW       = 4,
  parameter int NRD      = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_hi_i,
  input  logic [TW-1:0] wa_hi_i,
  input  logic [PW-1:0] wd_hi_i,
  input  logic          we_lo_i,
  input  logic [TW-1:0] wa_lo_i,
  input  logic [PW-1:0] wd_lo_i,
  input  logic [TW-1:0] rd_addr_i [NRD],
  output logic [PW-1:0] rd_data_o [NRD]
);
  logic [PW-1:0] mem_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [PW-1:0] RST_VAL =
      (e < LOG_INT) ? PW'(e) : PW'(PHYS_INT + e - LOG_INT);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[e] <= RST_VAL;
      else if (we_hi_i && wa_hi_i == TW'(e))    mem_q[e] <= wd_hi_i;
      else if (we_lo_i && wa_lo_i == TW'(e))    mem_q[e] <= wd_lo_i;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data_o[r] = mem_q[rd_addr_i[r]];
  end
endmodule

// File: rtl/rename_table_min.sv
module rename_table_min #(
  parameter int CW = 6
) (
  input  logic [CW-1:0] a_i,
  input  logic [CW-1:0] b_i,
  output logic [CW-1:0] y_o
);
  assign y_o = (a_i < b_i) ? a_i : b_i;
endmodule

// File: rtl/rename_table.sv
module rename_table
  import rename_table_pkg::*;
#(
  parameter int LOG_INT  = 8,
  parameter int LOG_FLT  = 8,
  parameter int PHYS_INT = 16,
  parameter int PHYS_FLT = 16,
  parameter int NUM_CTRL = 4,
  parameter int INT_ZERO = 0,
  parameter int FLT_ZERO = 8,
  parameter int NUM_RD   = 2,
  parameter int CW       = 6,
  localparam int LOG_TOT  = LOG_INT + LOG_FLT,
  localparam int PHYS_TOT = PHYS_INT + PHYS_FLT,
  localparam int AW       = $clog2(LOG_TOT + NUM_CTRL),
  localparam int PW       = $clog2(PHYS_TOT + NUM_CTRL),
  localparam int TW       = $clog2(LOG_TOT)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ren_valid_i,
  input  logic [AW-1:0]              ren_arch_i,
  output logic                       ren_ready_o,
  output logic [PW-1:0]              ren_new_o,
  output logic [PW-1:0]              ren_prev_o,
  output logic                       int_pop_o,
  input  logic [PW-1:0]              int_pop_reg_i,
  input  logic                       int_empty_i,
  output logic                       flt_pop_o,
  input  logic [PW-1:0]              flt_pop_reg_i,
  input  logic                       flt_empty_i,
  input  logic [CW-1:0]              int_free_cnt_i,
  input  logic [CW-1:0]              flt_free_cnt_i,
  output logic [CW-1:0]              free_cnt_o,
  input  logic [NUM_RD-1:0][AW-1:0]  lk_arch_i,
  output logic [NUM_RD-1:0][PW-1:0]  lk_phys_o,
  input  logic                       set_valid_i,
  input  logic [AW-1:0]              set_arch_i,
  input  logic [PW-1:0]              set_phys_i
);
  localparam int NRD = NUM_RD + 1;   // last read port serves the rename
  localparam logic [AW-1:0] INT_Z = AW'(INT_ZERO);
  localparam logic [AW-1:0] FLT_Z = AW'(FLT_ZERO);
  localparam logic [AW-1:0] TOT_LIM = AW'(LOG_TOT);

  logic [TW-1:0] rd_addr [NRD];
  logic [PW-1:0] rd_data [NRD];

  // rename side decode
  reg_cls_e      ren_cls;
  logic [PW-1:0] ren_ctrl;
  logic          ren_zero, need_int, need_flt;

  rename_table_decode #(
    .LOG_INT(LOG_INT), .LOG_FLT(LOG_FLT), .PHYS_TOT(PHYS_TOT), .AW(AW), .PW(PW)
  ) u_dec_ren (
    .arch_i(ren_arch_i), .cls_o(ren_cls), .ctrl_map_o(ren_ctrl)
  );

  assign ren_zero = (ren_arch_i == INT_Z) || (ren_arch_i == FLT_Z);
  assign need_int = ren_valid_i && !ren_zero && (ren_cls == RC_INT);
  assign need_flt = ren_valid_i && !ren_zero && (ren_cls == RC_FLT);

  assign ren_ready_o = !(need_int && int_empty_i) && !(need_flt && flt_empty_i);
  assign int_pop_o   = need_int && !int_empty_i;
  assign flt_pop_o   = need_flt && !flt_empty_i;

  assign rd_addr[NUM_RD] = ren_arch_i[TW-1:0];

  always_comb begin
    if (ren_cls == RC_CTRL) ren_prev_o = ren_ctrl;
    else                    ren_prev_o = rd_data[NUM_RD];
    if (ren_cls == RC_CTRL)     ren_new_o = ren_ctrl;
    else if (ren_zero)          ren_new_o = rd_data[NUM_RD];
    else if (ren_cls == RC_INT) ren_new_o = int_pop_reg_i;
    else                        ren_new_o = flt_pop_reg_i;
  end

  // lookup ports
  for (genvar r = 0; r < NUM_RD; r++) begin : g_lk
    reg_cls_e      lk_cls;
    logic [PW-1:0] lk_ctrl;
    rename_table_decode #(
      .LOG_INT(LOG_INT), .LOG_FLT(LOG_FLT), .PHYS_TOT(PHYS_TOT), .AW(AW), .PW(PW)
    ) u_dec_lk (
      .arch_i(lk_arch_i[r]), .cls_o(lk_cls), .ctrl_map_o(lk_ctrl)
    );
    assign rd_addr[r]   = lk_arch_i[r][TW-1:0];
    assign lk_phys_o[r] = (lk_cls == RC_CTRL) ? lk_ctrl : rd_data[r];
  end

  // storage: set-entry has priority over rename
  logic set_we;
  assign set_we = set_valid_i && (set_arch_i < TOT_LIM);

  rename_table_store #(
    .LOG_INT(LOG_INT), .ENTRIES(LOG_TOT), .PHYS_INT(PHYS_INT),
    .PW(PW), .TW(TW), .NRD(NRD)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_hi_i  (set_we),
    .wa_hi_i  (set_arch_i[TW-1:0]),
    .wd_hi_i  (set_phys_i),
    .we_lo_i  (int_pop_o || flt_pop_o),
    .wa_lo_i  (ren_arch_i[TW-1:0]),
    .wd_lo_i  (ren_new_o),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  rename_table_min #(.CW(CW)) u_min (
    .a_i(int_free_cnt_i), .b_i(flt_free_cnt_i), .y_o(free_cnt_o)
  );
endmodule

// File: rtl/rename_table_chk.sv
module rename_table_chk #(
  parameter int LOG_INT  = 8,
  parameter int LOG_FLT  = 8,
  parameter int PHYS_INT = 16,
  parameter int PHYS_FLT = 16,
  parameter int NUM_CTRL = 4,
  parameter int INT_ZERO = 0,
  parameter int FLT_ZERO = 8,
  parameter int CW       = 6,
  localparam int LOG_TOT  = LOG_INT + LOG_FLT,
  localparam int PHYS_TOT = PHYS_INT + PHYS_FLT,
  localparam int AW       = $clog2(LOG_TOT + NUM_CTRL),
  localparam int PW       = $clog2(PHYS_TOT + NUM_CTRL)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ren_valid_i,
  input logic [AW-1:0] ren_arch_i,
  input logic          ren_ready_o,
  input logic [PW-1:0] ren_new_o,
  input logic [PW-1:0] ren_prev_o,
  input logic          int_pop_o,
  input logic          int_empty_i,
  input logic          flt_pop_o,
  input logic [CW-1:0] int_free_cnt_i,
  input logic [CW-1:0] flt_free_cnt_i,
  input logic [CW-1:0] free_cnt_o
);
  localparam logic [AW-1:0] A_INT = AW'(LOG_INT);
  localparam logic [AW-1:0] A_TOT = AW'(LOG_TOT);
  localparam logic [AW-1:0] A_IZ  = AW'(INT_ZERO);
  localparam logic [AW-1:0] A_FZ  = AW'(FLT_ZERO);
  localparam logic [PW-1:0] P_INT = PW'(PHYS_INT);
  localparam logic [PW-1:0] P_TOT = PW'(PHYS_TOT);

  p_pop_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({int_pop_o, flt_pop_o}));

  p_int_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_pop_o |-> (ren_new_o < P_INT));

  p_flt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_pop_o |-> (ren_new_o >= P_INT && ren_new_o < P_TOT));

  p_zero_nopop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && (ren_arch_i == A_IZ || ren_arch_i == A_FZ))
      |-> (!int_pop_o && !flt_pop_o && ren_new_o == ren_prev_o));

  p_ctrl_fixed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && ren_arch_i >= A_TOT)
      |-> (ren_ready_o && !int_pop_o && !flt_pop_o &&
           ren_new_o == ren_prev_o && ren_new_o >= P_TOT));

  p_free_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_cnt_o <= int_free_cnt_i) && (free_cnt_o <= flt_free_cnt_i) &&
    (free_cnt_o == int_free_cnt_i || free_cnt_o == flt_free_cnt_i));

  p_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && ren_arch_i < A_INT && ren_arch_i != A_IZ && int_empty_i)
      |-> (!ren_ready_o && !int_pop_o));
endmodule

bind rename_table rename_table_chk #(
  .LOG_INT(LOG_INT), .LOG_FLT(LOG_FLT), .PHYS_INT(PHYS_INT), .PHYS_FLT(PHYS_FLT),
  .NUM_CTRL(NUM_CTRL), .INT_ZERO(INT_ZERO), .FLT_ZERO(FLT_ZERO), .CW(CW)
) u_chk (.*);

// File: tb/sim_rename_table.sv
module sim_rename_table;
  localparam int LI = 8, LF = 8, PI = 16, PF = 16, NC = 4;
  localparam int LT = LI + LF, PT = PI + PF;
  localparam int AW = 5, PW = 6, CW = 6;

  logic clk_i = 0, rst_ni = 0;
  logic ren_valid_i = 0;
  logic [AW-1:0] ren_arch_i = 0;
  logic ren_ready_o, int_pop_o, flt_pop_o;
  logic [PW-1:0] ren_new_o, ren_prev_o;
  logic [PW-1:0] int_pop_reg_i = 0, flt_pop_reg_i = 0;
  logic int_empty_i = 0, flt_empty_i = 0;
  logic [CW-1:0] int_free_cnt_i = 0, flt_free_cnt_i = 0, free_cnt_o;
  logic [1:0][AW-1:0] lk_arch_i = '0;
  logic [1:0][PW-1:0] lk_phys_o;
  logic set_valid_i = 0;
  logic [AW-1:0] set_arch_i = 0;
  logic [PW-1:0] set_phys_i = 0;

  int mdl [LT];
  int errors = 0, checks = 0;

  always #5 clk_i = ~clk_i;

  rename_table u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_map(input int a);
    return (a < LT) ? mdl[a] : a - LT + PT;
  endfunction

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < LT + NC; a++) begin
      lk_arch_i[0] = AW'(a);
      lk_arch_i[1] = AW'(LT + NC - 1 - a);
      #1;
      chk(req, int'(lk_phys_o[0]), exp_map(a));
      chk(req, int'(lk_phys_o[1]), exp_map(LT + NC - 1 - a));
    end
  endtask

  // drive a rename, check the combinational response, commit at the edge
  task automatic rename(input string req, input int a, input int ihead,
                        input int fhead, input bit exp_pop_i, input bit exp_pop_f,
                        input bit exp_rdy, input int exp_new, input int exp_prev);
    ren_valid_i = 1; ren_arch_i = AW'(a);
    int_pop_reg_i = PW'(ihead); flt_pop_reg_i = PW'(fhead);
    lk_arch_i[0] = AW'(a);
    #1;
    chk(req, int'(ren_ready_o), int'(exp_rdy));
    chk(req, int'(int_pop_o), int'(exp_pop_i));
    chk(req, int'(flt_pop_o), int'(exp_pop_f));
    chk(req, int'(ren_new_o), exp_new);
    chk(req, int'(ren_prev_o), exp_prev);
    chk("R9", int'(lk_phys_o[0]), exp_prev);
    step();
    if ((exp_pop_i || exp_pop_f) && !(set_valid_i && int'(set_arch_i) == a))
      mdl[a] = exp_new;
    ren_valid_i = 0;
  endtask

  initial begin
    #(20000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < LT; i++) mdl[i] = (i < LI) ? i : PI + i - LI;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1, R2: reset mapping and control offsets
    sweep("R1");
    chk("R8", int'(ren_ready_o), 1);

    // R3: integer renames (heads in integer pool), float renames
    for (int a = 1; a < LI; a++)
      rename("R3", a, 8 + a, 63, 1, 0, 1, 8 + a, mdl[a]);
    for (int a = LI + 1; a < LT; a++)
      rename("R3", a, 0, PI + a, 0, 1, 1, PI + a, mdl[a]);
    sweep("R3");

    // R4: zero registers
    rename("R4", 0, 9, 30, 0, 0, 1, mdl[0], mdl[0]);
    rename("R4", LI, 9, 30, 0, 0, 1, mdl[LI], mdl[LI]);
    sweep("R4");

    // R5: control registers, even with both lists empty
    int_empty_i = 1; flt_empty_i = 1;
    for (int a = LT; a < LT + NC; a++)
      rename("R5", a, 3, 20, 0, 0, 1, a - LT + PT, a - LT + PT);
    int_empty_i = 0; flt_empty_i = 0;

    // R6: set-entry on int, float, then control (ignored)
    set_valid_i = 1; set_arch_i = 3; set_phys_i = 5; step(); mdl[3] = 5;
    set_arch_i = 12; set_phys_i = 20; step(); mdl[12] = 20;
    set_arch_i = AW'(LT + 1); set_phys_i = 1; step();
    set_valid_i = 0;
    sweep("R6");

    // R8: stalls
    int_empty_i = 1;
    rename("R8", 2, 11, 0, 0, 0, 0, 11, mdl[2]);
    rename("R8", 10, 11, 27, 0, 1, 1, 27, mdl[10]);
    int_empty_i = 0; flt_empty_i = 1;
    rename("R8", 10, 0, 28, 0, 0, 0, 28, mdl[10]);
    rename("R8", 2, 12, 0, 1, 0, 1, 12, mdl[2]);
    flt_empty_i = 0;
    sweep("R8");

    // R10: set and rename on the same index
    set_valid_i = 1; set_arch_i = 4; set_phys_i = 9;
    rename("R10", 4, 14, 0, 1, 0, 1, 14, mdl[4]);
    mdl[4] = 9;
    set_valid_i = 0;
    set_arch_i = 13; set_phys_i = 22; set_valid_i = 1;
    rename("R10", 13, 0, 26, 0, 1, 1, 26, mdl[13]);
    mdl[13] = 22;
    set_valid_i = 0;
    sweep("R10");

    // R7: free count minimum over a grid
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        int_free_cnt_i = CW'(i * 9);
        flt_free_cnt_i = CW'(j * 7 + 3);
        #1;
        chk("R7", int'(free_cnt_o), (i * 9 < j * 7 + 3) ? i * 9 : j * 7 + 3);
      end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule